// File: doc/BRIEF.md
# Multi-PHY Cell Bus Receive Slave

This block is the receive half of a slave port on a shared 16-bit cell bus. The bus carries fixed-size cells from a master to several PHY-side slaves. The master picks one slave with a 5-bit address, and this port responds only when that address equals its programmed PHY number. On each rising clock edge where the master enables a transfer to this port, the port takes in one word together with its start-of-cell flag and its parity bit.

The port builds a cell of 27 words. Word 0 is the word that carries start-of-cell. Every word is checked for odd parity. When checking is active, a cell that holds any bad word is dropped and a saturating error counter goes up by one. Finished cells go into a two-cell buffer and leave through a valid/ready word stream. A cell-available flag tells the master whether the buffer can take another whole cell.

A 2-bit diagnostic field chooses the input source. In loop-back, the receiver takes its words from a local transmit source, which acts as master. In that mode the external bus inputs are ignored, and the cell-available output is still driven.

Top module: `cellbus_rx_slave`

## Requirements
- R1: In normal mode, a word is taken in on a rising edge only when `bus_en` is 1 and `bus_addr` equals `cfg_phy_id`. Words sent with the enable low or with another address have no effect.
- R2: A word with start-of-cell high is word 0 of a cell, and 27 accepted words make up one cell. Words that arrive while no cell is open and that lack start-of-cell are ignored. Idle cycles inside a cell do not break the framing.
- R3: A start-of-cell that arrives while a cell is open throws away the partial cell and begins a new cell with that word.
- R4: A word is in error when the XOR of its 16 data bits and its parity bit is 0. Odd parity means the 17 bits hold an odd number of ones.
- R5: When `cfg_par_ignore` is 0, a complete cell that holds at least one word in error is not delivered, and `perr_count` goes up by one.
- R6: When `cfg_par_ignore` is 1, cells are delivered whatever their parity, and `perr_count` does not change.
- R7: `perr_count` rises by one for each discarded cell and holds at its all-ones value once it gets there.
- R8: The buffer holds 54 words. `bus_clav` is 1 exactly when the free space is at least 27 words. Free space is 54 minus the committed unread words minus the words of the cell being received. `bus_clav` is 1 after reset.
- R9: A start-of-cell that arrives while fewer than 27 words are free outside the committed cells is ignored, along with the rest of that cell.
- R10: When `cfg_diag` is 01 (loop-back), words come from `lb_data`, `lb_soc`, `lb_en` and `lb_par`, and no address match is needed. All `bus_*` inputs are ignored.
- R11: When `cfg_diag` is 00, 10 or 11 (normal), the `lb_*` inputs are ignored.
- R12: Delivered cells leave in the order they arrived, and only after all 27 words are stored. `out_soc` is 1 on word 0 only. While `out_valid` is 1 and `out_ready` is 0, the output word and flags hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_phy_id | input | 5 | PHY number this port answers to |
| cfg_diag | input | 2 | Diagnostic mode: 01 loop-back, other values normal |
| cfg_par_ignore | input | 1 | 0 = parity checking active, 1 = parity ignored |
| bus_data | input | 16 | Cell word from the bus master |
| bus_soc | input | 1 | Start-of-cell flag from the bus master |
| bus_en | input | 1 | Master's transfer enable |
| bus_addr | input | 5 | PHY select from the bus master |
| bus_par | input | 1 | Odd parity bit for bus_data |
| lb_data | input | 16 | Local transmit word used in loop-back |
| lb_soc | input | 1 | Local transmit start-of-cell |
| lb_en | input | 1 | Local transmit enable |
| lb_par | input | 1 | Local transmit parity bit |
| bus_clav | output | 1 | Room for one more complete cell |
| out_valid | output | 1 | A stored word is available |
| out_soc | output | 1 | The output word is word 0 of its cell |
| out_data | output | 16 | Stored cell word |
| out_ready | input | 1 | Downstream takes the output word |
| perr_count | output | ERR_CNT_W | Saturating count of cells dropped for parity |

## Verification
The bench looks at the cases where a slip in framing or accounting shows up at the ports. These are a start-of-cell in the middle of a cell, a stray word with no start-of-cell, a cell addressed to another PHY, and a third cell sent while the buffer is full. A design that does not rewind the partial cell would deliver a mixed cell. A design that counts only committed words would keep `bus_clav` high during the second cell and could overflow. Loop-back is run with the external bus sending a matching, enabled cell of other data at the same time, and the reserved diagnostic codes are run with the local source active, so taking words from the wrong source shows up as wrong data. The error counter is built narrow so that it reaches saturation, which exposes any wrap-around. Parity-ignore mode is run to confirm that bad cells are delivered and not counted.

// File: rtl/cellbus_rx_pkg.sv
package cellbus_rx_pkg;

   typedef enum logic [1:0] {
      DIAG_NORMAL = 2'b00,
      DIAG_LOOP   = 2'b01,
      DIAG_RSV_A  = 2'b10,
      DIAG_RSV_B  = 2'b11
   } diag_e;

endpackage

// File: rtl/cellbus_rx_src_sel.sv
module cellbus_rx_src_sel
   import cellbus_rx_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 5,
   parameter bit LOOPBACK_EN = 1'b1
) (
   input  logic [1:0]        cfg_diag,
   input  logic [ADDR_W-1:0] cfg_phy_id,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              bus_soc,
   input  logic              bus_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_par,
   input  logic [DATA_W-1:0] lb_data,
   input  logic              lb_soc,
   input  logic              lb_en,
   input  logic              lb_par,
   output logic              beat_valid,
   output logic              beat_soc,
   output logic [DATA_W-1:0] beat_data,
   output logic              beat_perr
);

   logic loop_sel;
   logic sel_par;

   generate
      if (LOOPBACK_EN) begin : g_loop
         assign loop_sel = (cfg_diag == DIAG_LOOP);
      end else begin : g_noloop
         assign loop_sel = 1'b0;
      end
   endgenerate

   always_comb begin
      if (loop_sel) begin
         beat_valid = lb_en;
         beat_soc   = lb_soc;
         beat_data  = lb_data;
         sel_par    = lb_par;
      end else begin
         beat_valid = bus_en && (bus_addr == cfg_phy_id);
         beat_soc   = bus_soc;
         beat_data  = bus_data;
         sel_par    = bus_par;
      end
      // odd parity: 17 bits must hold an odd number of ones
      beat_perr = ~(^{beat_data, sel_par});
   end

endmodule

// File: rtl/cellbus_rx_framer.sv
module cellbus_rx_framer #(
   parameter int DATA_W     = 16,
   parameter int CELL_WORDS = 27,
   parameter int ERR_CNT_W  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_par_ignore,
   input  logic                 beat_valid,
   input  logic                 beat_soc,
   input  logic [DATA_W-1:0]    beat_data,
   input  logic                 beat_perr,
   input  logic                 room_cell,
   output logic                 wr_en,
   output logic                 wr_soc,
   output logic [DATA_W-1:0]    wr_data,
   output logic                 commit,
   output logic                 abort,
   output logic [ERR_CNT_W-1:0] perr_count
);

   localparam int IDX_W = $clog2(CELL_WORDS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_WORDS - 1);
   localparam logic [ERR_CNT_W-1:0] CNT_MAX = {ERR_CNT_W{1'b1}};

   logic                 in_cell_q;
   logic [IDX_W-1:0]     idx_q;
   logic                 err_q;
   logic [ERR_CNT_W-1:0] perr_q;

   logic start, cont, last, bad_cell;

   always_comb begin
      start    = beat_valid && beat_soc;
      cont     = beat_valid && !beat_soc && in_cell_q;
      last     = (idx_q == LAST_IDX);
      bad_cell = cont && last && (err_q || beat_perr) && !cfg_par_ignore;
      wr_en    = (start && room_cell) || (cont && !bad_cell);
      commit   = cont && last && !bad_cell;
      abort    = (start && in_cell_q) || bad_cell;
      wr_soc   = beat_soc;
      wr_data  = beat_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_cell_q <= 1'b0;
         idx_q     <= '0;
         err_q     <= 1'b0;
         perr_q    <= '0;
      end else begin
         if (start) begin
            in_cell_q <= room_cell;
            idx_q     <= IDX_W'(1);
            err_q     <= beat_perr;
         end else if (cont) begin
            if (last) begin
               in_cell_q <= 1'b0;
            end else begin
               idx_q <= idx_q + 1'b1;
               err_q <= err_q || beat_perr;
            end
         end
         if (bad_cell && (perr_q != CNT_MAX)) begin
            perr_q <= perr_q + 1'b1;
         end
      end
   end

   assign perr_count = perr_q;

   // R7: counter moves only by one step and never wraps from all-ones
   p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (perr_q != $past(perr_q)) |->
         ((perr_q == $past(perr_q) + 1'b1) && ($past(perr_q) != CNT_MAX)));

endmodule

// File: rtl/cellbus_rx_cellbuf.sv
module cellbus_rx_cellbuf #(
   parameter int DATA_W     = 16,
   parameter int CELL_WORDS = 27,
   parameter int BUF_CELLS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_soc,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              commit,
   input  logic              abort,
   output logic              room_cell,
   output logic              clav,
   output logic              out_valid,
   output logic              out_soc,
   output logic [DATA_W-1:0] out_data,
   input  logic              out_ready
);

   localparam int TOTAL = CELL_WORDS * BUF_CELLS;
   localparam int PTR_W = $clog2(TOTAL);
   localparam int CNT_W = $clog2(TOTAL + 1);
   localparam logic [CNT_W-1:0] ROOM_LIMIT = CNT_W'(TOTAL - CELL_WORDS);

   logic [DATA_W:0]    mem [TOTAL];
   logic [PTR_W-1:0]   wr_ptr_q, cm_ptr_q, rd_ptr_q;
   logic [CNT_W-1:0]   used_q, part_q;
   logic [PTR_W-1:0]   base_ptr, next_wr;
   logic [CNT_W-1:0]   base_part, next_part, add_w;
   logic               pop;

   function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(TOTAL - 1)) ? '0 : p + 1'b1;
   endfunction

   always_comb begin
      base_ptr  = abort ? cm_ptr_q : wr_ptr_q;
      base_part = abort ? '0 : part_q;
      next_wr   = wr_en ? ptr_inc(base_ptr) : base_ptr;
      next_part = base_part + CNT_W'(wr_en);
      add_w     = commit ? next_part : '0;
      out_valid = (used_q != '0);
      pop       = out_valid && out_ready;
      room_cell = (used_q <= ROOM_LIMIT);
      clav      = ((used_q + part_q) <= ROOM_LIMIT);
      {out_soc, out_data} = mem[rd_ptr_q];
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[base_ptr] <= {wr_soc, wr_data};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         cm_ptr_q <= '0;
         rd_ptr_q <= '0;
         used_q   <= '0;
         part_q   <= '0;
      end else begin
         wr_ptr_q <= next_wr;
         if (commit) begin
            cm_ptr_q <= next_wr;
            part_q   <= '0;
         end else begin
            part_q   <= next_part;
         end
         used_q <= used_q + add_w - CNT_W'(pop);
         if (pop) begin
            rd_ptr_q <= ptr_inc(rd_ptr_q);
         end
      end
   end

   // R8: a write never lands beyond the buffer's capacity
   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (({1'b0, used_q} + {1'b0, base_part}) < (CNT_W+1)'(TOTAL)));

   // R2: a cell is committed only with exactly one cell's worth of words
   p_commit_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (next_part == CNT_W'(CELL_WORDS)));

   // R12: output holds while stalled
   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_data) && $stable(out_soc)));

endmodule

// File: rtl/cellbus_rx_slave.sv
module cellbus_rx_slave #(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 5,
   parameter int CELL_WORDS  = 27,
   parameter int BUF_CELLS   = 2,
   parameter int ERR_CNT_W   = 8,
   parameter bit LOOPBACK_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    cfg_phy_id,
   input  logic [1:0]           cfg_diag,
   input  logic                 cfg_par_ignore,
   input  logic [DATA_W-1:0]    bus_data,
   input  logic                 bus_soc,
   input  logic                 bus_en,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_par,
   input  logic [DATA_W-1:0]    lb_data,
   input  logic                 lb_soc,
   input  logic                 lb_en,
   input  logic                 lb_par,
   output logic                 bus_clav,
   output logic                 out_valid,
   output logic                 out_soc,
   output logic [DATA_W-1:0]    out_data,
   input  logic                 out_ready,
   output logic [ERR_CNT_W-1:0] perr_count
);

   initial begin
      assert (DATA_W >= 1)     else $error("DATA_W must be positive");
      assert (ADDR_W >= 1)     else $error("ADDR_W must be positive");
      assert (CELL_WORDS >= 2) else $error("CELL_WORDS must be at least 2");
      assert (BUF_CELLS >= 1)  else $error("BUF_CELLS must be at least 1");
      assert (ERR_CNT_W >= 1)  else $error("ERR_CNT_W must be positive");
   end

   logic              beat_valid, beat_soc, beat_perr;
   logic [DATA_W-1:0] beat_data;
   logic              wr_en, wr_soc, commit, abort, room_cell;
   logic [DATA_W-1:0] wr_data;

   cellbus_rx_src_sel #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOOPBACK_EN(LOOPBACK_EN)
   ) i_src_sel (
      .cfg_diag   (cfg_diag),
      .cfg_phy_id (cfg_phy_id),
      .bus_data   (bus_data),
      .bus_soc    (bus_soc),
      .bus_en     (bus_en),
      .bus_addr   (bus_addr),
      .bus_par    (bus_par),
      .lb_data    (lb_data),
      .lb_soc     (lb_soc),
      .lb_en      (lb_en),
      .lb_par     (lb_par),
      .beat_valid (beat_valid),
      .beat_soc   (beat_soc),
      .beat_data  (beat_data),
      .beat_perr  (beat_perr)
   );

   cellbus_rx_framer #(
      .DATA_W(DATA_W), .CELL_WORDS(CELL_WORDS), .ERR_CNT_W(ERR_CNT_W)
   ) i_framer (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_par_ignore (cfg_par_ignore),
      .beat_valid     (beat_valid),
      .beat_soc       (beat_soc),
      .beat_data      (beat_data),
      .beat_perr      (beat_perr),
      .room_cell      (room_cell),
      .wr_en          (wr_en),
      .wr_soc         (wr_soc),
      .wr_data        (wr_data),
      .commit         (commit),
      .abort          (abort),
      .perr_count     (perr_count)
   );

   cellbus_rx_cellbuf #(
      .DATA_W(DATA_W), .CELL_WORDS(CELL_WORDS), .BUF_CELLS(BUF_CELLS)
   ) i_cellbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_soc    (wr_soc),
      .wr_data   (wr_data),
      .commit    (commit),
      .abort     (abort),
      .room_cell (room_cell),
      .clav      (bus_clav),
      .out_valid (out_valid),
      .out_soc   (out_soc),
      .out_data  (out_data),
      .out_ready (out_ready)
   );

endmodule

// File: tb/test_cellbus_rx_slave.sv
`timescale 1ns/1ps
module test_cellbus_rx_slave;

   localparam logic [4:0] MY_ID = 5'h0B;
   localparam int NW = 27;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  cfg_phy_id = MY_ID;
   logic [1:0]  cfg_diag = 2'b00;
   logic        cfg_par_ignore = 1'b0;
   logic [15:0] bus_data = '0;
   logic        bus_soc = 1'b0, bus_en = 1'b0, bus_par = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [15:0] lb_data = '0;
   logic        lb_soc = 1'b0, lb_en = 1'b0, lb_par = 1'b0;
   logic        bus_clav, out_valid, out_soc, out_ready = 1'b0;
   logic [15:0] out_data;
   logic [1:0]  perr_count;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   cellbus_rx_slave #(.ERR_CNT_W(2)) i_cellbus_rx_slave (
      .clk(clk), .rst_n(rst_n), .cfg_phy_id(cfg_phy_id), .cfg_diag(cfg_diag),
      .cfg_par_ignore(cfg_par_ignore), .bus_data(bus_data), .bus_soc(bus_soc),
      .bus_en(bus_en), .bus_addr(bus_addr), .bus_par(bus_par), .lb_data(lb_data),
      .lb_soc(lb_soc), .lb_en(lb_en), .lb_par(lb_par), .bus_clav(bus_clav),
      .out_valid(out_valid), .out_soc(out_soc), .out_data(out_data),
      .out_ready(out_ready), .perr_count(perr_count)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // one word on the chosen source; the other source carries conflicting traffic
   task automatic drive_word(input bit use_lb, input logic [4:0] addr, input bit en,
                             input bit soc, input logic [15:0] d, input bit bad);
      logic p;
      @(negedge clk);
      p = bad ? (^d) : ~(^d);
      if (use_lb) begin
         lb_en = en; lb_soc = soc; lb_data = d; lb_par = p;
         bus_en = 1'b1; bus_addr = MY_ID; bus_soc = soc; bus_data = ~d; bus_par = ^d;
      end else begin
         bus_en = en; bus_addr = addr; bus_soc = soc; bus_data = d; bus_par = p;
         lb_en = 1'b1; lb_soc = soc; lb_data = ~d; lb_par = ^d;
      end
   endtask

   task automatic idle();
      @(negedge clk);
      bus_en = 1'b0; lb_en = 1'b0; bus_soc = 1'b0; lb_soc = 1'b0;
   endtask

   task automatic send_cell(input bit use_lb, input logic [4:0] addr, input bit en,
                            input bit first_soc, input logic [7:0] base,
                            input int first, input int nwords, input int bad_idx);
      for (int i = first; i < first + nwords; i++) begin
         drive_word(use_lb, addr, en, (i == 0) && first_soc, {base, 8'(i)}, i == bad_idx);
      end
      idle();
   endtask

   task automatic read_cell(input logic [7:0] base, input string req);
      bit ok = 1'b1;
      logic [31:0] act = '0, exp = '0;
      for (int i = 0; i < NW; i++) begin
         @(negedge clk);
         if (ok && (!out_valid || out_data != {base, 8'(i)} || out_soc != (i == 0))) begin
            ok  = 1'b0;
            act = {out_valid, out_soc, 14'd0, out_data};
            exp = {1'b1, 1'(i == 0), 14'd0, base, 8'(i)};
         end
         out_ready = 1'b1;
      end
      @(negedge clk);
      out_ready = 1'b0;
      chk(ok, req, act, exp);
   endtask

   task automatic t_reset();
      chk(bus_clav == 1'b1, "R8 clav after reset", 32'(bus_clav), 1);
      chk(out_valid == 1'b0, "R12 no output after reset", 32'(out_valid), 0);
      chk(perr_count == 2'd0, "R7 counter after reset", 32'(perr_count), 0);
   endtask

   task automatic t_basic();
      send_cell(0, MY_ID, 1, 1, 8'hA1, 0, NW, 99);
      read_cell(8'hA1, "R1 R2 R12 matched cell");
      chk(out_valid == 1'b0, "R12 one cell only", 32'(out_valid), 0);
   endtask

   task automatic t_ignored();
      send_cell(0, 5'h0C, 1, 1, 8'hB2, 0, NW, 99);
      chk(out_valid == 1'b0, "R1 other address ignored", 32'(out_valid), 0);
      send_cell(0, MY_ID, 0, 1, 8'hB3, 0, NW, 99);
      chk(out_valid == 1'b0, "R1 enable low ignored", 32'(out_valid), 0);
      send_cell(0, MY_ID, 1, 0, 8'hB4, 0, NW, 99);
      chk(out_valid == 1'b0, "R2 words without soc ignored", 32'(out_valid), 0);
   endtask

   task automatic t_abort();
      send_cell(0, MY_ID, 1, 1, 8'hC1, 0, 10, 99);
      send_cell(0, MY_ID, 1, 1, 8'hC2, 0, NW, 99);
      read_cell(8'hC2, "R3 restart after mid-cell soc");
      chk(out_valid == 1'b0, "R3 partial cell dropped", 32'(out_valid), 0);
   endtask

   task automatic t_parity();
      send_cell(0, MY_ID, 1, 1, 8'hD1, 0, NW, 13);
      chk(out_valid == 1'b0, "R4 R5 bad cell discarded", 32'(out_valid), 0);
      chk(perr_count == 2'd1, "R5 counter bumped", 32'(perr_count), 1);
      cfg_par_ignore = 1'b1;
      send_cell(0, MY_ID, 1, 1, 8'hD2, 0, NW, 0);
      read_cell(8'hD2, "R6 bad cell delivered when ignored");
      chk(perr_count == 2'd1, "R6 counter unchanged", 32'(perr_count), 1);
      cfg_par_ignore = 1'b0;
   endtask

   task automatic t_fill();
      logic [15:0] held;
      send_cell(0, MY_ID, 1, 1, 8'hE1, 0, NW, 99);
      chk(bus_clav == 1'b1, "R8 clav with one cell stored", 32'(bus_clav), 1);
      send_cell(0, MY_ID, 1, 1, 8'hE2, 0, 1, 99);
      chk(bus_clav == 1'b0, "R8 clav drops during second cell", 32'(bus_clav), 0);
      send_cell(0, MY_ID, 1, 1, 8'hE2, 1, NW - 1, 99);
      chk(bus_clav == 1'b0, "R8 clav low when full", 32'(bus_clav), 0);
      send_cell(0, MY_ID, 1, 1, 8'hE3, 0, NW, 99);
      held = out_data;
      repeat (3) @(negedge clk);
      chk(out_valid && out_data == held && out_soc, "R12 output held while stalled",
          32'(out_data), 32'(held));
      read_cell(8'hE1, "R12 first cell in order");
      read_cell(8'hE2, "R12 second cell in order");
      chk(out_valid == 1'b0, "R9 cell sent while full ignored", 32'(out_valid), 0);
      chk(bus_clav == 1'b1, "R8 clav back after drain", 32'(bus_clav), 1);
   endtask

   task automatic t_loop();
      cfg_diag = 2'b01;
      send_cell(1, 5'h1F, 1, 1, 8'hF1, 0, NW, 99);
      read_cell(8'hF1, "R10 loop-back source used, bus ignored");
      chk(out_valid == 1'b0, "R10 no bus cell in loop-back", 32'(out_valid), 0);
      cfg_diag = 2'b10;
      send_cell(0, MY_ID, 1, 1, 8'hF2, 0, NW, 99);
      read_cell(8'hF2, "R11 reserved 10 acts normal");
      cfg_diag = 2'b11;
      send_cell(0, MY_ID, 1, 1, 8'hF3, 0, NW, 99);
      read_cell(8'hF3, "R11 reserved 11 acts normal");
      chk(out_valid == 1'b0, "R11 local source ignored", 32'(out_valid), 0);
      cfg_diag = 2'b00;
   endtask

   task automatic t_saturate();
      send_cell(0, MY_ID, 1, 1, 8'h51, 0, NW, 26);
      send_cell(0, MY_ID, 1, 1, 8'h52, 0, NW, 5);
      chk(perr_count == 2'd3, "R7 counter reaches max", 32'(perr_count), 3);
      send_cell(0, MY_ID, 1, 1, 8'h53, 0, NW, 1);
      chk(perr_count == 2'd3, "R7 counter saturates", 32'(perr_count), 3);
      chk(out_valid == 1'b0, "R5 bad cells not delivered", 32'(out_valid), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_ignored();
      t_abort();
      t_parity();
      t_fill();
      t_loop();
      t_saturate();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule